// File: doc/BRIEF.md
# Line-Memory Serial Address Pointer

This block produces the serial access address for a single port of a line-organised field memory. The pointer has two dimensions. A line counter (X) picks the line, and a word counter (Y) picks the word inside that line. The block also holds a one-line address register that is loaded from an input bus. That register is the target of an address jump.

On every enabled clock the block either steps the pointer by one word or carries out exactly one repositioning request:
- hold the current line,
- return to the origin,
- advance to the next line,
- jump to the stored line,
- load the address register.

When two or more requests arrive together, the block flags an error for one cycle and ignores all of them.

A pointer-valid flag stays low after power-up. It rises only once a complete dummy line has been walked after the pointer was positioned by a repositioning request. A small state machine tracks this with three states:
- `VS_UNINIT` moves to `VS_DUMMY` on any positioning request (hold, origin, next line, jump).
- `VS_DUMMY` restarts its line on a further positioning request. It moves to `VS_LIVE` when a serial step wraps the word counter from its last word.
- `VS_LIVE` is kept until reset.

Top module: `lptr_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first edges after it rises, `x_addr` and `y_addr` are 0, `ptr_valid` and `req_err` are 0, and the address register is 0 (a jump as the first request gives line 0).
- R2: With `en` high and no request, `y_addr` increments by one per clock. From `WORDS-1` it wraps to 0 and `x_addr` increments, and `x_addr` wraps from `LINES-1` to 0.
- R3: An origin request sets `x_addr` and `y_addr` to 0 and leaves the address register unchanged.
- R4: A hold request sets `y_addr` to 0 and keeps `x_addr`.
- R5: A next-line request sets `y_addr` to 0 and increments `x_addr`, wrapping from `LINES-1` to 0.
- R6: A jump request sets `y_addr` to 0 and `x_addr` to the stored address register. A stored value of `LINES` or more gives line 0.
- R7: A load request stores `addr_in` in the address register and holds the pointer for that cycle. No other operation changes the register.
- R8: With `en` high and more than one of the five request inputs high, `req_err` is 1 on the next cycle and the pointer and register are unchanged. Otherwise `req_err` is 0.
- R9: With `en` low, all request inputs and `addr_in` are ignored: pointer, register and `ptr_valid` hold, and `req_err` is 0 on the next cycle.
- R10: `ptr_valid` rises on the edge of the serial step that wraps `y_addr` from `WORDS-1`. Only a line whose walk began at a positioning request (hold, origin, next line, jump) counts, and it must not be interrupted by a further positioning request. Once high, `ptr_valid` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Cycle enable; when low, nothing changes |
| req_hold | input | 1 | Restart at word 0 of the current line |
| req_orig | input | 1 | Return to line 0, word 0 |
| req_linc | input | 1 | Move to word 0 of the next line |
| req_jump | input | 1 | Move to word 0 of the stored line |
| req_load | input | 1 | Store `addr_in` in the address register |
| addr_in | input | $clog2(LINES) | Line address for a load |
| x_addr | output | $clog2(LINES) | Current line address |
| y_addr | output | $clog2(WORDS) | Current word address |
| ptr_valid | output | 1 | Pointer has completed a dummy line |
| req_err | output | 1 | Previous enabled cycle carried conflicting requests |

## Verification
The assertions expect the request inputs and `addr_in` to be settled at each rising edge; they place no limit on combinations. Conflicting requests, disabled cycles and out-of-range stored lines are therefore legal, and each has a defined outcome. The stimulus changes inputs only at falling edges. It drives directed sequences first and then weighted random cycles that mix single requests, request pairs and disabled cycles. The register is loaded with both legal and out-of-range lines so that jumps exercise both branches of R6.

// File: rtl/lptr_pkg.sv
package lptr_pkg;

    // operation chosen for one clock
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_STEP,
        OP_HOLD,
        OP_ORIG,
        OP_LINC,
        OP_JUMP,
        OP_LOAD
    } lptr_op_e;

    // pointer qualification states
    typedef enum logic [1:0] {
        VS_UNINIT,
        VS_DUMMY,
        VS_LIVE
    } lptr_vstate_e;

    // request vector bit order: {load, jump, linc, orig, hold}
    localparam int NUM_REQ = 5;

endpackage

// File: rtl/lptr_cmd_decode.sv
module lptr_cmd_decode
    import lptr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [NUM_REQ-1:0] req,
    output lptr_op_e           op,
    output logic               err
);

    logic conflict;

    always_comb begin
        op       = OP_IDLE;
        conflict = 1'b0;
        if (en) begin
            unique case (req)
                5'b00000: op = OP_STEP;
                5'b00001: op = OP_HOLD;
                5'b00010: op = OP_ORIG;
                5'b00100: op = OP_LINC;
                5'b01000: op = OP_JUMP;
                5'b10000: op = OP_LOAD;
                default: begin
                    op       = OP_IDLE;
                    conflict = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err <= 1'b0;
        else        err <= conflict;
    end

    // R8: conflicting requests raise the flag one cycle later
    a_r8_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ($countones(req) > 1)) |=> err);

    // R9: a disabled cycle never raises the flag
    a_r9_no_err_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !err);

    // R8: the flag reports only true conflicts
    a_r8_err_only_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ($countones(req) <= 1)) |=> !err);

endmodule

// File: rtl/lptr_xy_counter.sv
module lptr_xy_counter
    import lptr_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int LINES = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  lptr_op_e                 op,
    input  logic [$clog2(LINES)-1:0] addr_in,
    output logic [$clog2(LINES)-1:0] x,
    output logic [$clog2(WORDS)-1:0] y,
    output logic                     line_done
);

    localparam int XW = $clog2(LINES);
    localparam int YW = $clog2(WORDS);
    localparam logic [XW-1:0] XLAST = XW'(LINES - 1);
    localparam logic [YW-1:0] YLAST = YW'(WORDS - 1);

    logic [XW-1:0] areg;
    logic [XW-1:0] x_next_line;
    logic [XW-1:0] x_jump;

    assign x_next_line = (x == XLAST) ? '0 : x + XW'(1);
    assign x_jump      = (areg <= XLAST) ? areg : '0;
    assign line_done   = (op == OP_STEP) && (y == YLAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x    <= '0;
            y    <= '0;
            areg <= '0;
        end else begin
            unique case (op)
                OP_STEP: begin
                    if (y == YLAST) begin
                        y <= '0;
                        x <= x_next_line;
                    end else begin
                        y <= y + YW'(1);
                    end
                end
                OP_HOLD: y <= '0;
                OP_ORIG: begin
                    x <= '0;
                    y <= '0;
                end
                OP_LINC: begin
                    x <= x_next_line;
                    y <= '0;
                end
                OP_JUMP: begin
                    x <= x_jump;
                    y <= '0;
                end
                OP_LOAD: areg <= addr_in;
                default: ;
            endcase
        end
    end

    // R2: pointer never leaves the field
    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (y <= YLAST) && (x <= XLAST));

    // R3: origin clears both counters
    a_r3_orig_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ORIG) |=> (x == '0) && (y == '0));

    // R4: hold keeps the line
    a_r4_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> (y == '0) && (x == $past(x)));

    // R5: next line with wrap
    a_r5_next_line: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LINC) |=> (y == '0) &&
            (x == (($past(x) == XLAST) ? '0 : XW'($past(x) + XW'(1)))));

    // R7: register changes only on a load
    a_r7_areg_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_LOAD) |=> $stable(areg));

    // R8: an idle cycle freezes the pointer
    a_r8_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> $stable(x) && $stable(y));

endmodule

// File: rtl/lptr_valid_fsm.sv
module lptr_valid_fsm
    import lptr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lptr_op_e op,
    input  logic     line_done,
    output logic     valid
);

    lptr_vstate_e state, state_nx;
    logic         positioning;

    assign positioning = (op == OP_HOLD) || (op == OP_ORIG) ||
                         (op == OP_LINC) || (op == OP_JUMP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= VS_UNINIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            VS_UNINIT: if (positioning) state_nx = VS_DUMMY;
            VS_DUMMY:  if (line_done)   state_nx = VS_LIVE;
            VS_LIVE:   state_nx = VS_LIVE;
            default:   state_nx = VS_UNINIT;
        endcase
    end

    always_comb begin
        unique case (state)
            VS_LIVE: valid = 1'b1;
            default: valid = 1'b0;
        endcase
    end

    // R10: a wrap before any positioning request does not qualify the pointer
    a_r10_uninit_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VS_UNINIT && !positioning) |=> (state == VS_UNINIT));

endmodule

// File: rtl/lptr_ctrl.sv
module lptr_ctrl
    import lptr_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int LINES = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     req_hold,
    input  logic                     req_orig,
    input  logic                     req_linc,
    input  logic                     req_jump,
    input  logic                     req_load,
    input  logic [$clog2(LINES)-1:0] addr_in,
    output logic [$clog2(LINES)-1:0] x_addr,
    output logic [$clog2(WORDS)-1:0] y_addr,
    output logic                     ptr_valid,
    output logic                     req_err
);

    localparam int YW = $clog2(WORDS);
    localparam logic [YW-1:0] YLAST = YW'(WORDS - 1);

    lptr_op_e           op;
    logic               line_done;
    logic [NUM_REQ-1:0] req_vec;

    assign req_vec = {req_load, req_jump, req_linc, req_orig, req_hold};

    lptr_cmd_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .req   (req_vec),
        .op    (op),
        .err   (req_err)
    );

    lptr_xy_counter #(.WORDS(WORDS), .LINES(LINES)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .addr_in   (addr_in),
        .x         (x_addr),
        .y         (y_addr),
        .line_done (line_done)
    );

    lptr_valid_fsm u_vfsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .line_done (line_done),
        .valid     (ptr_valid)
    );

    // R9: disabled cycles change nothing visible
    a_r9_frozen_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(x_addr) && $stable(y_addr) && $stable(ptr_valid));

    // R10: qualification arrives with a word wrap
    a_r10_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ptr_valid) |-> (y_addr == '0) && ($past(y_addr) == YLAST));

    // R10: qualification is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_valid |=> ptr_valid);

endmodule

// File: tb/lptr_ctrl_bench.sv
module lptr_ctrl_bench;

    localparam int W  = 8;
    localparam int L  = 6;
    localparam int XW = $clog2(L);
    localparam int YW = $clog2(W);

    localparam logic [4:0] RQ_NONE = 5'b00000;
    localparam logic [4:0] RQ_HOLD = 5'b00001;
    localparam logic [4:0] RQ_ORIG = 5'b00010;
    localparam logic [4:0] RQ_LINC = 5'b00100;
    localparam logic [4:0] RQ_JUMP = 5'b01000;
    localparam logic [4:0] RQ_LOAD = 5'b10000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          req_hold = 1'b0, req_orig = 1'b0, req_linc = 1'b0;
    logic          req_jump = 1'b0, req_load = 1'b0;
    logic [XW-1:0] addr_in = '0;
    logic [XW-1:0] x_addr;
    logic [YW-1:0] y_addr;
    logic          ptr_valid;
    logic          req_err;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    int mx = 0, my = 0, ma = 0, mvs = 0, merr = 0;

    always #5 clk = ~clk;

    lptr_ctrl #(.WORDS(W), .LINES(L)) u_lptr_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .req_hold  (req_hold),
        .req_orig  (req_orig),
        .req_linc  (req_linc),
        .req_jump  (req_jump),
        .req_load  (req_load),
        .addr_in   (addr_in),
        .x_addr    (x_addr),
        .y_addr    (y_addr),
        .ptr_valid (ptr_valid),
        .req_err   (req_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic e, input logic [4:0] r);
        if (!e) return "R9";
        if ($countones(r) > 1) return "R8";
        case (r)
            RQ_NONE: return "R2";
            RQ_HOLD: return "R4";
            RQ_ORIG: return "R3";
            RQ_LINC: return "R5";
            RQ_JUMP: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_step(input logic e, input logic [4:0] r, input int a);
        bit pos;
        pos = 0;
        if (!e) begin
            merr = 0;
            return;
        end
        if ($countones(r) > 1) begin
            merr = 1;
            return;
        end
        merr = 0;
        case (r)
            RQ_LOAD: ma = a;
            RQ_ORIG: begin mx = 0; my = 0; pos = 1; end
            RQ_HOLD: begin my = 0; pos = 1; end
            RQ_LINC: begin mx = (mx + 1) % L; my = 0; pos = 1; end
            RQ_JUMP: begin mx = (ma < L) ? ma : 0; my = 0; pos = 1; end
            default: begin
                if (my == W - 1) begin
                    my = 0;
                    mx = (mx + 1) % L;
                    if (mvs == 1) mvs = 2;
                end else begin
                    my = my + 1;
                end
            end
        endcase
        if (pos && mvs == 0) mvs = 1;
    endtask

    // called at a falling edge; leaves at the next falling edge after checking
    task automatic cyc(input logic e, input logic [4:0] r, input int a);
        string t;
        en = e;
        {req_load, req_jump, req_linc, req_orig, req_hold} = r;
        addr_in = XW'(a);
        @(posedge clk);
        model_step(e, r, a);
        @(negedge clk);
        t = tag_of(e, r);
        check(int'(x_addr) == mx, t, "x_addr", int'(x_addr), mx);
        check(int'(y_addr) == my, t, "y_addr", int'(y_addr), my);
        check(int'(req_err) == merr, (merr != 0) ? "R8" : t, "req_err", int'(req_err), merr);
        check(int'(ptr_valid) == ((mvs == 2) ? 1 : 0), "R10", "ptr_valid",
              int'(ptr_valid), (mvs == 2) ? 1 : 0);
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(x_addr == '0, "R1", "x_addr in reset", int'(x_addr), 0);
        check(y_addr == '0, "R1", "y_addr in reset", int'(y_addr), 0);
        check(ptr_valid == 1'b0, "R1", "ptr_valid in reset", int'(ptr_valid), 0);
        check(req_err == 1'b0, "R1", "req_err in reset", int'(req_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 register cleared: a jump lands on line 0
        cyc(1, RQ_NONE, 0);
        cyc(1, RQ_NONE, 0);
        cyc(1, RQ_JUMP, 0);
        check(x_addr == '0, "R1", "jump after reset", int'(x_addr), 0);
        // R10 restart: a serial walk with no positioning does not count
        cyc(1, RQ_ORIG, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mx = 0; my = 0; ma = 0; mvs = 0; merr = 0;
        for (int i = 0; i < 20; i++) cyc(1, RQ_NONE, 0);   // R2 wrap, R10 stays low
        check(ptr_valid == 1'b0, "R10", "no qualify without positioning", int'(ptr_valid), 0);
        cyc(1, RQ_LOAD, 4);                                // R7
        cyc(1, RQ_NONE, 0);
        cyc(1, RQ_JUMP, 0);                                // R6 to line 4
        for (int i = 0; i < 3; i++) cyc(1, RQ_NONE, 0);
        cyc(1, RQ_HOLD, 0);                                // R10 restart of dummy line
        for (int i = 0; i < 5; i++) cyc(1, RQ_NONE, 0);
        cyc(1, RQ_ORIG, 0);                                // R3
        for (int i = 0; i < W; i++) cyc(1, RQ_NONE, 0);    // R10 qualifies here
        cyc(1, RQ_JUMP, 0);                                // R3 kept register 4
        check(int'(x_addr) == 4, "R3", "register kept across origin", int'(x_addr), 4);
        cyc(1, RQ_LINC, 0);
        cyc(1, RQ_LINC, 0);                                // R5 wraps 5 -> 0
        cyc(1, RQ_HOLD | RQ_ORIG, 0);                      // R8
        cyc(1, RQ_LOAD | RQ_JUMP, 1);                      // R8 register untouched
        cyc(1, RQ_JUMP, 0);
        cyc(0, RQ_LOAD, 2);                                // R9
        cyc(0, RQ_ORIG, 0);
        cyc(0, RQ_HOLD | RQ_LINC, 0);
        cyc(1, RQ_JUMP, 0);
        check(int'(x_addr) == 4, "R9", "disabled load ignored", int'(x_addr), 4);
        cyc(1, RQ_LOAD, 7);                                // R6 out of range
        cyc(1, RQ_LINC, 0);
        cyc(1, RQ_JUMP, 0);
        check(x_addr == '0, "R6", "out-of-range jump", int'(x_addr), 0);
        for (int i = 0; i < 60; i++) cyc(1, RQ_NONE, 0);   // R2 full field wrap
        for (int i = 0; i < 400; i++) begin
            int       pick;
            logic [4:0] r;
            logic     e;
            e = ($urandom_range(0, 9) != 0);
            pick = $urandom_range(0, 99);
            if (pick < 65) r = RQ_NONE;
            else if (pick < 93) r = 5'(1 << $urandom_range(0, 4));
            else r = 5'(1 << $urandom_range(0, 4)) | 5'(1 << $urandom_range(0, 4));
            cyc(e, r, $urandom_range(0, 7));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule